// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM with an 18-bit word split into two 9-bit byte lanes. It takes a new read or write command on every enabled clock and never needs an idle cycle between reads and writes. A write carries its address and command in one cycle and its data two enabled clocks later. Read data leaves an output register two enabled clocks after the address is taken. Because a write stays pending in a two-stage address pipeline, a read can target a word whose data has not yet landed in the array. Per-lane forwarding returns the newest value in that case.

Commands are either loaded, with a fresh external address plus chip selects and write enable, or advanced. An advance repeats the previous operation at the next address of a four-word burst, in linear or interleaved order. A clock enable freezes the whole block for any number of edges. The shared data bus is modelled as separate input data, output data and a drive flag. The drive flag is gated by an asynchronous output enable and stays low during write data phases.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at enabled edge k produces the stored word on `rdata_o` with `drive_o` high (when `oe_ni` is low) after enabled edge k+2.
- R2: A write loaded at enabled edge k stores the value on `wdata_i` sampled at enabled edge k+2 at the address given at edge k.
- R3: `bw_ni[0]` guards bits 8:0 and `bw_ni[1]` guards bits 17:9. Both are active low and apply only to writes. A lane whose select is high keeps its old contents.
- R4: On a load cycle the device is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Any other combination is a deselect: nothing is written, and `drive_o` is low after edge k+2.
- R5: An edge with `cen_ni`=1 changes no state and performs no write. `rdata_o` and `drive_o` hold, and every pending latency grows by one edge.
- R6: A read that follows writes to the same address, back to back with no gap, returns the newest data lane by lane. Lanes that were not written come from earlier contents.
- R7: `drive_o` is the registered read-valid ANDed combinationally with the inverse of `oe_ni`. It is low in the output cycle of every write.
- R8: With `mode_i`=0, the n-th advance (`adv_i`=1) after a load uses address bits 1:0 equal to (start + n) mod 4. The upper bits stay those of the load.
- R9: With `mode_i`=1, the n-th advance uses address bits 1:0 equal to start XOR n, and the upper bits stay fixed.
- R10: An advance repeats the operation type of the last load. On advance cycles the chip enables and `we_ni` are ignored, so an advance after a deselect stays a deselect.
- R11: While `rst_ni` is low, `drive_o` is low. A write still waiting for its data when reset arrives is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | LANES | Byte-lane write selects, active low |
| addr_i | input | ADDR_W | Word address |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data, two enabled edges after its command |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | Bus drive flag |

## Verification
The delicate case is a write's data commit and a read of the same word falling on the same edge. The read must merge the arriving lanes with the array contents. Directed runs provoke this with write/read chains to one address using partial lane masks. Long pseudo-random runs add a bias toward a few addresses, mixed with stalls between a write and its data phase. Each returned word is judged against a reference array in the bench, updated only at the edge where a write's data is due.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt, lo;
  op_e               last_q;

  assign cnt_nxt = cnt_q + 2'd1;
  assign lo      = mode_i ? (base_q[1:0] ^ cnt_nxt) : (base_q[1:0] + cnt_nxt);

  always_comb begin
    if (load_i) begin
      op_o   = sel_i ? (wr_i ? OP_WR : OP_RD) : OP_NOP;
      addr_o = addr_i;
    end else begin
      op_o   = last_q;
      addr_o = {base_q[ADDR_W-1:2], lo};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      last_q <= OP_NOP;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        last_q <= op_o;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  AST_BURST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> $stable(base_q)); // R8
  AST_BURST_OP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (last_q == $past(last_q))); // R10
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [LANES-1:0]         lane_we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [LANES*LANE_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zt_sram_fwd.sv
module zt_sram_fwd #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic [LANES*LANE_W-1:0] arr_i,
  input  logic [LANES*LANE_W-1:0] fwd_i,
  input  logic [LANES-1:0]        hit_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*LANE_W +: LANE_W] = hit_i[l] ? fwd_i[l*LANE_W +: LANE_W]
                                                 : arr_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cen_ni,
  input  logic                     ce1_ni,
  input  logic                     ce2_i,
  input  logic                     ce3_ni,
  input  logic                     adv_i,
  input  logic                     we_ni,
  input  logic [LANES-1:0]         bw_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     mode_i,
  input  logic                     oe_ni,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  output logic [LANES*LANE_W-1:0]  rdata_o,
  output logic                     drive_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en, sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  assign en  = ~cen_ni;
  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  zt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (~adv_i),
    .sel_i  (sel),
    .wr_i   (~we_ni),
    .mode_i (mode_i),
    .addr_i (addr_i),
    .op_o   (cmd_op),
    .addr_o (cmd_addr)
  );

  // stage 1: command, stage 2: write awaiting data / read data captured
  op_e               op1_q, op2_q;
  logic [ADDR_W-1:0] addr1_q, addr2_q;
  logic [LANES-1:0]  lwe1_q, lwe2_q;
  logic [DATA_W-1:0] rd2_q, out_q;
  logic              out_vld_q;

  logic              commit;
  logic [LANES-1:0]  hit;
  logic [DATA_W-1:0] arr_rd, merged;

  assign commit = en && (op2_q == OP_WR);
  assign hit    = ((op2_q == OP_WR) && (addr2_q == addr1_q)) ? lwe2_q : '0;

  zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .we_i      (commit),
    .lane_we_i (lwe2_q),
    .waddr_i   (addr2_q),
    .wdata_i   (wdata_i),
    .raddr_i   (addr1_q),
    .rdata_o   (arr_rd)
  );

  // the data landing this edge is newer than the array word
  zt_sram_fwd #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
    .arr_i  (arr_rd),
    .fwd_i  (wdata_i),
    .hit_i  (hit),
    .data_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1_q     <= OP_NOP;
      op2_q     <= OP_NOP;
      addr1_q   <= '0;
      addr2_q   <= '0;
      lwe1_q    <= '0;
      lwe2_q    <= '0;
      rd2_q     <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else if (en) begin
      op1_q     <= cmd_op;
      addr1_q   <= cmd_addr;
      lwe1_q    <= ~bw_ni;
      op2_q     <= op1_q;
      addr2_q   <= addr1_q;
      lwe2_q    <= lwe1_q;
      if (op1_q == OP_RD) rd2_q <= merged;
      out_vld_q <= (op2_q == OP_RD);
      if (op2_q == OP_RD) out_q <= rd2_q;
    end
  end

  assign rdata_o = out_q;
  assign drive_o = out_vld_q & ~oe_ni;

  AST_READ_REACHES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && op2_q == OP_RD) |=> out_vld_q); // R1
  AST_WR_PHASE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && op2_q == OP_WR) |=> !drive_o); // R7
  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !adv_i && !sel) |=> (op1_q == OP_NOP)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(out_q) && $stable(out_vld_q) && $stable(op2_q))); // R5
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam logic [2:0] SEL = 3'b010;  // {ce1_n, ce2, ce3_n}
  localparam logic [2:0] DES = 3'b100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cen_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic          adv_i = 1'b0, we_ni = 1'b1, mode_i = 1'b0, oe_ni = 1'b0;
  logic [1:0]    bw_ni = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  zt_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
    .ce3_ni(ce3_ni), .adv_i(adv_i), .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr_i),
    .mode_i(mode_i), .oe_ni(oe_ni), .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  int vecs = 0;
  int errs = 0;
  logic [DW-1:0] ref_mem [64];
  logic [31:0]   rs = 32'h1357_9bdf;

  // pipeline slots: 0 nop, 1 read, 2 write
  int            q1_op = 0, q2_op = 0;
  logic [AW-1:0] q1_a = '0, q2_a = '0;
  logic [1:0]    q1_bw = '0, q2_bw = '0;
  logic [DW-1:0] q1_d = '0, q2_d = '0;
  string         q1_t = "R11", q2_t = "R11";
  // burst model
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  int            b_last = 0;

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit stall, input bit adv, input logic [2:0] ce, input bit we,
                      input logic [1:0] bwn, input logic [AW-1:0] a, input string tag);
    int            nop;
    logic [AW-1:0] na;
    logic [DW-1:0] pd;
    logic          pv;
    nop = 0;
    na  = a;
    cen_ni = stall; adv_i = adv; ce1_ni = ce[2]; ce2_i = ce[1]; ce3_ni = ce[0];
    we_ni = ~we; bw_ni = bwn; addr_i = a;
    wdata_i = (!stall && q2_op == 2) ? q2_d : rnd();
    pd = rdata_o;
    pv = drive_o;
    @(posedge clk);
    @(negedge clk);
    if (stall) begin
      chk(drive_o == pv, "R5", "drive held on stall", drive_o, pv);
      if (pv) chk(rdata_o == pd, "R5", "data held on stall", rdata_o, pd);
      return;
    end
    if (!adv) begin
      nop = (ce == SEL) ? (we ? 2 : 1) : 0;
      b_base = a; b_cnt = 2'd0; b_last = nop;
    end else begin
      b_cnt = b_cnt + 2'd1;
      na = {b_base[AW-1:2], mode_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
      nop = b_last;
    end
    if (q2_op == 2) begin
      if (!q2_bw[0]) ref_mem[q2_a][8:0]  = q2_d[8:0];
      if (!q2_bw[1]) ref_mem[q2_a][17:9] = q2_d[17:9];
    end
    chk(drive_o == (q2_op == 1 && !oe_ni), q2_t, "drive_o", drive_o, (q2_op == 1 && !oe_ni));
    if (q2_op == 1 && drive_o)
      chk(rdata_o == ref_mem[q2_a], q2_t, "read data", rdata_o, ref_mem[q2_a]);
    q2_op = q1_op; q2_a = q1_a; q2_bw = q1_bw; q2_d = q1_d; q2_t = q1_t;
    q1_op = nop;   q1_a = na;   q1_bw = bwn;   q1_d = rnd();  q1_t = tag;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] bwn, input string t);
    step(0, 0, SEL, 1, bwn, a, t);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string t);
    step(0, 0, SEL, 0, 2'b00, a, t);
  endtask
  task automatic idle(input string t);
    step(0, 0, DES, 0, 2'b00, '0, t);
  endtask

  task automatic burst(input logic [AW-1:0] base, input bit we, input string t);
    step(0, 0, SEL, we, 2'b00, base, t);
    for (int n = 1; n < 4; n++) step(0, 1, DES, ~we, 2'b00, 6'h3f, t); // R10 ce/we ignored
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk(drive_o == 1'b0, "R11", "drive in reset", drive_o, 0);
    rst_n = 1'b1;
    idle("R11"); idle("R11"); idle("R11");

    // R2: fill then back-to-back readback
    for (int i = 0; i < 64; i++) wr(i[AW-1:0], 2'b00, "R2");
    for (int i = 0; i < 64; i++) rd(i[AW-1:0], "R2");
    idle("R2"); idle("R2");

    // R3: lane selects
    wr(6'd5, 2'b00, "R3"); wr(6'd5, 2'b10, "R3"); rd(6'd5, "R3");
    wr(6'd5, 2'b01, "R3"); wr(6'd5, 2'b11, "R3"); idle("R3"); rd(6'd5, "R3");
    idle("R3"); idle("R3");

    // R6: zero-gap read after write
    wr(6'd10, 2'b00, "R6"); rd(6'd10, "R6"); wr(6'd10, 2'b10, "R6"); rd(6'd10, "R6");
    rd(6'd10, "R6"); wr(6'd11, 2'b00, "R6"); wr(6'd10, 2'b01, "R6"); rd(6'd10, "R6");
    rd(6'd11, "R6"); idle("R6"); idle("R6");

    // R4: all chip-enable combinations
    for (int c = 0; c < 8; c++) begin
      step(0, 0, c[2:0], 1, 2'b00, 6'd9, "R4");
      step(0, 0, c[2:0], 0, 2'b00, 6'd9, "R4");
    end
    rd(6'd9, "R4"); idle("R4"); idle("R4");

    // R5: stalls between write, its data phase, and a read
    wr(6'd12, 2'b00, "R5"); step(1, 0, SEL, 1, 2'b00, 6'd13, "R5");
    step(1, 0, SEL, 1, 2'b00, 6'd14, "R5"); idle("R5");
    step(1, 0, SEL, 1, 2'b00, 6'd15, "R5"); rd(6'd12, "R5");
    step(1, 0, SEL, 0, 2'b00, 6'd12, "R5"); idle("R5");
    step(1, 1, SEL, 0, 2'b00, 6'd12, "R5"); idle("R5"); idle("R5");

    // R7: output enable gating
    rd(6'd7, "R7"); oe_ni = 1'b1; idle("R7"); idle("R7");
    oe_ni = 1'b0; #1;
    chk(drive_o == 1'b1, "R7", "drive after oe low", drive_o, 1);
    chk(rdata_o == ref_mem[7], "R7", "data after oe low", rdata_o, ref_mem[7]);
    wr(6'd7, 2'b00, "R7"); idle("R7"); idle("R7");

    // R8 / R9: bursts from every start offset
    mode_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      burst(6'h24 | s[AW-1:0], 1, "R8"); burst(6'h24 | s[AW-1:0], 0, "R8");
    end
    idle("R8"); idle("R8");
    mode_i = 1'b1;
    for (int s = 0; s < 4; s++) begin
      burst(6'h34 | s[AW-1:0], 1, "R9"); burst(6'h34 | s[AW-1:0], 0, "R9");
    end
    idle("R9"); idle("R9");
    mode_i = 1'b0;

    // R10: advance after deselect stays idle
    step(0, 0, DES, 1, 2'b00, 6'd0, "R10");
    step(0, 1, SEL, 1, 2'b00, 6'd0, "R10");
    step(0, 1, SEL, 1, 2'b00, 6'd0, "R10");
    burst(6'd0, 0, "R10"); idle("R10"); idle("R10");

    // R11: reset drops a write still waiting for data
    wr(6'd3, 2'b00, "R11"); idle("R11");
    rst_n = 1'b0;
    @(negedge clk);
    chk(drive_o == 1'b0, "R11", "drive in reset", drive_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    q1_op = 0; q2_op = 0; b_last = 0; b_cnt = '0; b_base = '0;
    rd(6'd3, "R11"); idle("R11"); idle("R11");

    // mixed traffic in both burst orders
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      for (int i = 0; i < 1500; i++) begin
        logic [2:0]    ce;
        logic [AW-1:0] a;
        bit            adv;
        string         t;
        r   = rnd();
        adv = (r[4:3] == 2'b00);
        ce  = (r[6:5] != 2'b00) ? SEL : r[9:7];
        a   = r[13] ? {3'b000, r[16:14]} : r[21:16];
        t   = adv ? (m == 1 ? "R9" : "R8") : (ce == SEL ? "R6" : "R4");
        step(r[2:0] == 3'b000, adv, ce, r[10], r[12:11], a, t);
      end
      idle("R6"); idle("R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule